// File: doc/BRIEF.md
# Packet-gated transmit byte buffer

This block sits between a host that writes single bytes and a serial transmitter. Each byte the host writes goes into an internal FIFO. The transmitter is held off while a packet is still being assembled. It is fed only once the buffered bytes form a complete packet.

A packet is complete in one of two cases. The first is when a carriage return (0x0D) or line feed (0x0A) is written, which suits text lines. The second is when no byte has been accepted for a programmable number of clock cycles, which suits binary frames. At 125 MHz a timeout of 12500 cycles gives a 100 µs gap. That suits short packets of about sixteen bytes sent every millisecond to a 230 kbit/s line.

Released bytes leave through a valid/ready stream. Bytes written while a packet is draining wait for their own end of packet.

The host side is a plain write strobe with no back-pressure. The host is expected to watch `full`. A write made while the FIFO is full is discarded and recorded in a sticky flag.

The transmit side follows valid/ready rules. `tx_valid` and `tx_data` hold steady until the transmitter raises `tx_ready`. A byte moves on every clock edge where both are high. The transmitter may hold `tx_ready` low for any number of cycles without loss.

Top module: `ptb_packet_buffer`

## Requirements
- R1: While no complete packet is buffered, `tx_valid` stays low even when `empty` is low and `tx_ready` is high.
- R2: Once `tx_valid` is high it stays high, and `tx_data` stays unchanged, until a clock edge with `tx_ready` high. Bytes leave in the order they were accepted.
- R3: An accepted write whose data is 0x0D or 0x0A is stored as the last byte of the packet. At that same clock edge every byte then in the FIFO is released, so `tx_valid` is high in the cycle that follows.
- R4: When unreleased bytes are held and no write is accepted for IDLE_CYCLES clock edges, all held bytes are released. `tx_valid` rises at the IDLE_CYCLES-th edge after the last accepted write.
- R5: Every accepted write restarts the idle count. Writes spaced fewer than IDLE_CYCLES cycles apart never trigger a timeout release.
- R6: Bytes accepted after a release are not part of the released packet. When that packet has drained, `tx_valid` falls and `empty` stays low until the newer bytes get their own terminator or timeout.
- R7: `full` is high when DEPTH bytes are stored. A write made while `full` is high is dropped: it stores nothing, releases nothing even if it is a terminator, and does not restart the idle count.
- R8: `overflow` goes high on a dropped write and stays high until reset.
- R9: After reset `empty` is 1, and `full`, `overflow` and `tx_valid` are 0. The idle count does not run while nothing unreleased is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe, one byte per cycle |
| wr_data | input | 8 | Byte written by the host |
| tx_valid | output | 1 | Released byte available to transmitter |
| tx_data | output | 8 | Byte at the head of the FIFO |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |
| full | output | 1 | FIFO holds DEPTH bytes |
| empty | output | 1 | FIFO holds no byte |
| overflow | output | 1 | Sticky: a write was dropped while full |

## Verification
A terminator release is registered at the same edge that captures the terminator. The bench therefore expects `tx_valid` high at the first falling edge after that write.

A timeout release comes at the IDLE_CYCLES-th rising edge after the last accepted write. The bench counts falling edges from the write. It checks `tx_valid` low one edge early and high exactly on time.

For the dropped-write test, the count starts from the last accepted byte, not from the dropped one. Stream checks read `tx_data` at the falling edge before each transfer edge. Inputs are driven only at falling edges, so every sample is taken half a period after the registers settle.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CODE_CR = 8'h0D;
  localparam logic [BYTE_W-1:0] CODE_LF = 8'h0A;

  function automatic logic is_line_end(input logic [BYTE_W-1:0] b);
    return (b == CODE_CR) || (b == CODE_LF);
  endfunction
endpackage

// File: rtl/ptb_fifo.sv
module ptb_fifo
  import ptb_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_pop,
  output logic [BYTE_W-1:0] rd_data,
  output logic              wr_accept,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign wr_accept = wr_req && !full;
  assign rd_data   = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_accept) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_accept) wptr <= step(wptr);
      if (rd_pop)    rptr <= step(rptr);
      count <= count + CW'(wr_accept) - CW'(rd_pop);
    end
  end

  // R7: a write against a full FIFO leaves the occupancy untouched
  a_r7_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_req && !rd_pop |=> count == $past(count));
endmodule

// File: rtl/ptb_idle_timer.sv
module ptb_idle_timer #(
  parameter int IDLE_CYCLES = 12500,
  localparam int TW = $clog2(IDLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic pending,
  output logic fire
);
  logic [TW-1:0] cnt;

  assign fire = pending && !restart && (cnt == TW'(IDLE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (restart || !pending || fire) cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end

  // R4: the idle count never passes the timeout limit
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < TW'(IDLE_CYCLES));
endmodule

// File: rtl/ptb_drain_ctrl.sv
module ptb_drain_ctrl
  import ptb_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_accept,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              idle_fire,
  input  logic              pop,
  input  logic [CW-1:0]     count,
  output logic              tx_valid,
  output logic              pending
);
  logic [CW-1:0] released;
  logic [CW-1:0] count_next;
  logic          release_now;

  assign count_next  = count + CW'(wr_accept) - CW'(pop);
  assign release_now = (wr_accept && is_line_end(wr_data)) || idle_fire;
  assign tx_valid    = (released != '0);
  assign pending     = (count > released);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           released <= '0;
    else if (release_now) released <= count_next;
    else                  released <= released - CW'(pop);
  end

  // R6: the released window never exceeds what the FIFO holds
  a_r6_release_bound: assert property (@(posedge clk) disable iff (!rst_n)
    released <= count);
endmodule

// File: rtl/ptb_packet_buffer.sv
module ptb_packet_buffer
  import ptb_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int IDLE_CYCLES = 12500,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              full,
  output logic              empty,
  output logic              overflow
);
  logic          wr_accept, pop, pending, idle_fire;
  logic [CW-1:0] count;

  assign pop = tx_valid && tx_ready;

  ptb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_en), .wr_data(wr_data),
    .rd_pop(pop), .rd_data(tx_data), .wr_accept(wr_accept),
    .count(count), .full(full), .empty(empty)
  );

  ptb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .restart(wr_accept),
    .pending(pending), .fire(idle_fire)
  );

  ptb_drain_ctrl #(.CW(CW)) u_drain (
    .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept), .wr_data(wr_data),
    .idle_fire(idle_fire), .pop(pop), .count(count),
    .tx_valid(tx_valid), .pending(pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              overflow <= 1'b0;
    else if (wr_en && full)  overflow <= 1'b1;
  end

  // R2: an offered byte is held until the transmitter takes it
  a_r2_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R8: the overflow flag only clears through reset
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: tb/tb_ptb_packet_buffer.sv
module tb_ptb_packet_buffer;
  localparam int DEPTH = 8;
  localparam int IDLE  = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_ready = 1'b0;
  logic       tx_valid, full, empty, overflow;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] exp_b [16];

  always #4 clk = ~clk;

  ptb_packet_buffer #(.DEPTH(DEPTH), .IDLE_CYCLES(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .full(full), .empty(empty), .overflow(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain(input string req, input int n);
    tx_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      chk({req, " valid"}, tx_valid, 1);
      chk({req, " data"}, tx_data, exp_b[i]);
      @(negedge clk);
    end
    tx_ready = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; wr_en = 1'b0; tx_ready = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset;
    chk("R9 empty", empty, 1);
    chk("R9 full", full, 0);
    chk("R9 overflow", overflow, 0);
    chk("R9 tx_valid", tx_valid, 0);
  endtask

  task automatic t_line_feed;
    wr(8'h41); wr(8'h42); wr(8'h43);
    tx_ready = 1'b1;
    idle(3);
    chk("R1 not empty", empty, 0);
    chk("R1 held back", tx_valid, 0);
    tx_ready = 1'b0;
    wr(8'h0A);
    chk("R3 released on LF", tx_valid, 1);
    idle(3);
    chk("R2 held valid", tx_valid, 1);
    chk("R2 held data", tx_data, 8'h41);
    exp_b[0] = 8'h41; exp_b[1] = 8'h42; exp_b[2] = 8'h43; exp_b[3] = 8'h0A;
    drain("R2 R3 LF packet", 4);
    chk("R2 done", tx_valid, 0);
    chk("R2 empty", empty, 1);
  endtask

  task automatic t_carriage_return;
    wr(8'h55); wr(8'h0D);
    chk("R3 released on CR", tx_valid, 1);
    exp_b[0] = 8'h55; exp_b[1] = 8'h0D;
    drain("R3 CR packet", 2);
    chk("R3 empty", empty, 1);
  endtask

  task automatic t_timeout;
    idle(IDLE + 5);
    chk("R9 no run while empty", tx_valid, 0);
    wr(8'h01); wr(8'h02);
    idle(IDLE - 1);
    chk("R4 one edge early", tx_valid, 0);
    idle(1);
    chk("R4 on time", tx_valid, 1);
    exp_b[0] = 8'h01; exp_b[1] = 8'h02;
    drain("R4 timeout packet", 2);
  endtask

  task automatic t_restart;
    int seen = 0;
    for (int k = 0; k < 4; k++) begin
      wr(8'h10 + 8'(k));
      for (int i = 0; i < IDLE - 3; i++) begin
        if (tx_valid) seen = 1;
        @(negedge clk);
      end
    end
    chk("R5 restarted", seen, 0);
    idle(3);
    chk("R5 late flush", tx_valid, 1);
    for (int k = 0; k < 4; k++) exp_b[k] = 8'h10 + 8'(k);
    drain("R5 packet", 4);
  endtask

  task automatic t_during_drain;
    wr(8'h61); wr(8'h62); wr(8'h0A);
    wr(8'h78); wr(8'h79);
    exp_b[0] = 8'h61; exp_b[1] = 8'h62; exp_b[2] = 8'h0A;
    drain("R6 first packet", 3);
    chk("R6 gap valid", tx_valid, 0);
    chk("R6 gap empty", empty, 0);
    wr(8'h0A);
    exp_b[0] = 8'h78; exp_b[1] = 8'h79; exp_b[2] = 8'h0A;
    drain("R6 second packet", 3);
    chk("R6 empty", empty, 1);
  endtask

  task automatic t_full;
    for (int k = 0; k < DEPTH; k++) wr(8'h20 + 8'(k));
    chk("R7 full", full, 1);
    chk("R8 no overflow yet", overflow, 0);
    wr(8'h0A);
    chk("R7 dropped LF no release", tx_valid, 0);
    chk("R8 overflow set", overflow, 1);
    idle(IDLE - 2);
    chk("R7 no timer restart early", tx_valid, 0);
    idle(1);
    chk("R7 timeout from last kept", tx_valid, 1);
    for (int k = 0; k < DEPTH; k++) exp_b[k] = 8'h20 + 8'(k);
    drain("R7 kept bytes", DEPTH);
    chk("R7 LF not stored", tx_valid, 0);
    chk("R7 empty after", empty, 1);
    chk("R8 still set", overflow, 1);
    do_reset();
    chk("R8 cleared by reset", overflow, 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_line_feed();
    t_carriage_return();
    t_timeout();
    t_restart();
    t_during_drain();
    t_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule